// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Fetcher

This block walks a circular table of receive-buffer descriptors held in system memory. When a start pulse arrives while it is idle, it reads one descriptor through a simple request/valid read port. A descriptor has four 16-bit fields. The low and high halves of the buffer address come first, then the low and high halves of the remaining word count. When all four fields have arrived, the block presents the assembled 32-bit buffer address and the 32-bit word count together. It then moves its read pointer to the next descriptor and pulses done.

The table's position in memory is set by three 16-bit pointers: a ring start, a ring end and a producer (write) pointer. A 16-bit upper address selects the memory window. The read pointer does not wrap on a power of two. It returns to the ring start when, after the advance, it equals the ring end. If the advanced pointer lands on the write pointer, the ring has run out of fresh descriptors and a sticky exhausted flag is raised. A wide-bus mode puts each field in a 32-bit slot, which doubles the stride between descriptors.

Top module: `rxres_fetch`

## Requirements
- R1: After reset, busy, done, the memory request and the exhausted flag are 0, and the buffer address, word count and read pointer are all 0.
- R2: A start pulse seen while idle raises busy on the next cycle. Exactly four memory reads are then issued in field order. In narrow mode (wide_i=0) field k is read at {upper, read_pointer + 2*k}.
- R3: In wide mode (wide_i=1) field k is read at {upper, read_pointer + 4*k}. The upper address is captured when the start is accepted.
- R4: The request stays high and its address stays unchanged until the matching read-valid is seen.
- R5: buf_addr_o becomes {field1, field0} and word_cnt_o becomes {field3, field2}. Both change only in the cycle done is high, never part-way through a fetch.
- R6: After a fetch the read pointer has advanced by 8 in narrow mode and by 16 in wide mode.
- R7: If the advanced read pointer equals the ring end, the read pointer becomes the ring start instead.
- R8: If the final read pointer equals the write pointer, exhausted_o goes to 1 with done. It stays at 1 until an exhaust-clear pulse; if a set and a clear coincide, the set wins.
- R9: done_o is a single-cycle pulse, and busy_o is 0 in that same cycle (the resource-read command is cleared).
- R10: A start pulse or a read-pointer load that arrives while busy is ignored. The fetch in progress issues no extra read, and the final pointer is that of the original fetch.
- R11: Only the low 16 bits of each read word are used; the upper bits of the read data have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Fetch command pulse |
| wide_i | input | 1 | 1 = 32-bit field slots, 0 = 16-bit slots |
| upper_i | input | 16 | Upper half of every memory address |
| ring_start_i | input | 16 | First descriptor position of the ring |
| ring_end_i | input | 16 | Position one past the last descriptor |
| write_ptr_i | input | 16 | Producer pointer used for the exhaust compare |
| ptr_load_i | input | 1 | Load the read pointer (idle only) |
| ptr_load_val_i | input | 16 | Value for a read-pointer load |
| exh_clr_i | input | 1 | Clear the exhausted flag |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_valid_i | input | 1 | Read data valid for the pending request |
| mem_rdata_i | input | 32 | Read data; the field is in the low 16 bits |
| busy_o | output | 1 | Fetch in progress (resource-read command) |
| done_o | output | 1 | One-cycle fetch-complete pulse |
| buf_addr_o | output | 32 | Loaded buffer address |
| word_cnt_o | output | 32 | Loaded remaining word count |
| rd_ptr_o | output | 16 | Current read pointer |
| exhausted_o | output | 1 | Ring exhausted flag |

## Verification
The bound checker tests the following on every cycle:
- a request is only made while busy;
- a pending request keeps its address until valid;
- an accepted start leads to busy;
- done never overlaps busy;
- the loaded address and count move only with done;
- the exhausted flag rises only with done and only where the read pointer equals the write pointer.

The directed scenarios cover what depends on values:
- the exact field addresses in both slot modes;
- the assembled buffer address and count;
- the stride;
- the wrap to the ring start;
- the sticky flag and its clear;
- discarding of junk in the upper data bits;
- starts and pointer loads that arrive mid-fetch and must be ignored.

// File: rtl/rxres_pkg.sv
package rxres_pkg;
   localparam int unsigned DESC_FIELDS = 4;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_READ = 1'b1
   } fetch_state_t;
endpackage

// File: rtl/rxres_seq.sv
module rxres_seq
   import rxres_pkg::*;
#(
   parameter int unsigned NUM_FIELDS = DESC_FIELDS,
   localparam int unsigned IDX_W = $clog2(NUM_FIELDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             valid_i,
   output logic             busy_o,
   output logic             beat_o,
   output logic             last_beat_o,
   output logic             accept_o,
   output logic [IDX_W-1:0] idx_o,
   output logic             done_o
);
   fetch_state_t     state_q;
   logic [IDX_W-1:0] idx_q;

   assign busy_o      = (state_q == ST_READ);
   assign beat_o      = busy_o && valid_i;
   assign last_beat_o = beat_o && (idx_q == IDX_W'(NUM_FIELDS - 1));
   assign accept_o    = (state_q == ST_IDLE) && start_i;
   assign idx_o       = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  state_q <= ST_READ;
                  idx_q   <= '0;
               end
            end
            ST_READ: begin
               if (last_beat_o) begin
                  state_q <= ST_IDLE;
                  idx_q   <= '0;
                  done_o  <= 1'b1;
               end else if (beat_o) begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxres_gather.sv
module rxres_gather
   import rxres_pkg::*;
#(
   parameter int unsigned FIELD_W    = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_FIELDS = DESC_FIELDS,
   localparam int unsigned IDX_W = $clog2(NUM_FIELDS),
   localparam int unsigned HALF  = NUM_FIELDS / 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    beat_i,
   input  logic                    commit_i,
   input  logic [IDX_W-1:0]        idx_i,
   input  logic [DATA_W-1:0]       rdata_i,
   output logic [HALF*FIELD_W-1:0] buf_addr_o,
   output logic [HALF*FIELD_W-1:0] word_cnt_o
);
   logic [FIELD_W-1:0]            field_in;
   logic [NUM_FIELDS*FIELD_W-1:0] flat;

   assign field_in = rdata_i[FIELD_W-1:0];

   for (genvar k = 0; k < NUM_FIELDS; k++) begin : g_field
      if (k < NUM_FIELDS - 1) begin : g_shadow
         logic [FIELD_W-1:0] hold_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hold_q <= '0;
            end else if (beat_i && (idx_i == IDX_W'(k))) begin
               hold_q <= field_in;
            end
         end
         assign flat[k*FIELD_W +: FIELD_W] = hold_q;
      end else begin : g_direct
         assign flat[k*FIELD_W +: FIELD_W] = field_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_addr_o <= '0;
         word_cnt_o <= '0;
      end else if (commit_i) begin
         buf_addr_o <= flat[HALF*FIELD_W-1:0];
         word_cnt_o <= flat[NUM_FIELDS*FIELD_W-1:HALF*FIELD_W];
      end
   end
endmodule

// File: rtl/rxres_ptr.sv
module rxres_ptr #(
   parameter int unsigned PTR_W     = 16,
   parameter int unsigned STRIDE_SH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [PTR_W-1:0] load_val_i,
   input  logic             idle_i,
   input  logic             advance_i,
   input  logic             wide_i,
   input  logic [PTR_W-1:0] ring_start_i,
   input  logic [PTR_W-1:0] ring_end_i,
   input  logic [PTR_W-1:0] wr_ptr_i,
   input  logic             exh_clr_i,
   output logic [PTR_W-1:0] rd_ptr_o,
   output logic             exhausted_o
);
   logic [PTR_W-1:0] stride;
   logic [PTR_W-1:0] stepped;
   logic [PTR_W-1:0] next_ptr;
   logic             hit_wp;

   assign stride   = wide_i ? (PTR_W'(1) << (STRIDE_SH + 1)) : (PTR_W'(1) << STRIDE_SH);
   assign stepped  = rd_ptr_o + stride;
   assign next_ptr = (stepped == ring_end_i) ? ring_start_i : stepped;
   assign hit_wp   = (next_ptr == wr_ptr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr_o <= '0;
      end else if (advance_i) begin
         rd_ptr_o <= next_ptr;
      end else if (load_i && idle_i) begin
         rd_ptr_o <= load_val_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exhausted_o <= 1'b0;
      end else if (advance_i && hit_wp) begin
         exhausted_o <= 1'b1;
      end else if (exh_clr_i) begin
         exhausted_o <= 1'b0;
      end
   end
endmodule

// File: rtl/rxres_fetch.sv
module rxres_fetch
   import rxres_pkg::*;
#(
   parameter int unsigned PTR_W   = 16,
   parameter int unsigned UPPER_W = 16,
   parameter int unsigned FIELD_W = 16,
   parameter int unsigned DATA_W  = 32,
   parameter bit          WIDE_EN = 1'b1,
   localparam int unsigned ADDR_W   = UPPER_W + PTR_W,
   localparam int unsigned OUT_W    = (DESC_FIELDS / 2) * FIELD_W,
   localparam int unsigned IDX_W    = $clog2(DESC_FIELDS),
   localparam int unsigned SLOT_SH  = $clog2(FIELD_W / 8),
   localparam int unsigned STRIDE_SH = SLOT_SH + IDX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic               wide_i,
   input  logic [UPPER_W-1:0] upper_i,
   input  logic [PTR_W-1:0]   ring_start_i,
   input  logic [PTR_W-1:0]   ring_end_i,
   input  logic [PTR_W-1:0]   write_ptr_i,
   input  logic               ptr_load_i,
   input  logic [PTR_W-1:0]   ptr_load_val_i,
   input  logic               exh_clr_i,
   output logic               mem_req_o,
   output logic [ADDR_W-1:0]  mem_addr_o,
   input  logic               mem_valid_i,
   input  logic [DATA_W-1:0]  mem_rdata_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [OUT_W-1:0]   buf_addr_o,
   output logic [OUT_W-1:0]   word_cnt_o,
   output logic [PTR_W-1:0]   rd_ptr_o,
   output logic               exhausted_o
);
   if (FIELD_W % 8 != 0 || FIELD_W < 8) begin : g_bad_field
      $error("FIELD_W must be a whole number of bytes");
   end
   if (DATA_W < FIELD_W) begin : g_bad_data
      $error("DATA_W must hold one field");
   end
   if (PTR_W <= STRIDE_SH + 1) begin : g_bad_ptr
      $error("PTR_W too small for the descriptor stride");
   end

   logic               wide_eff;
   logic               wide_q;
   logic [UPPER_W-1:0] upper_q;
   logic               beat;
   logic               last_beat;
   logic               accept;
   logic [IDX_W-1:0]   idx;
   logic [PTR_W-1:0]   field_off;

   if (WIDE_EN) begin : g_wide
      assign wide_eff = wide_i;
   end else begin : g_narrow
      assign wide_eff = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upper_q <= '0;
         wide_q  <= 1'b0;
      end else if (accept) begin
         upper_q <= upper_i;
         wide_q  <= wide_eff;
      end
   end

   rxres_seq #(.NUM_FIELDS(DESC_FIELDS)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .valid_i     (mem_valid_i),
      .busy_o      (busy_o),
      .beat_o      (beat),
      .last_beat_o (last_beat),
      .accept_o    (accept),
      .idx_o       (idx),
      .done_o      (done_o)
   );

   rxres_gather #(
      .FIELD_W    (FIELD_W),
      .DATA_W     (DATA_W),
      .NUM_FIELDS (DESC_FIELDS)
   ) u_gather (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_i     (beat),
      .commit_i   (last_beat),
      .idx_i      (idx),
      .rdata_i    (mem_rdata_i),
      .buf_addr_o (buf_addr_o),
      .word_cnt_o (word_cnt_o)
   );

   rxres_ptr #(
      .PTR_W     (PTR_W),
      .STRIDE_SH (STRIDE_SH)
   ) u_ptr (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (ptr_load_i),
      .load_val_i   (ptr_load_val_i),
      .idle_i       (!busy_o),
      .advance_i    (last_beat),
      .wide_i       (wide_q),
      .ring_start_i (ring_start_i),
      .ring_end_i   (ring_end_i),
      .wr_ptr_i     (write_ptr_i),
      .exh_clr_i    (exh_clr_i),
      .rd_ptr_o     (rd_ptr_o),
      .exhausted_o  (exhausted_o)
   );

   assign field_off  = wide_q ? (PTR_W'(idx) << (SLOT_SH + 1)) : (PTR_W'(idx) << SLOT_SH);
   assign mem_req_o  = busy_o;
   assign mem_addr_o = {upper_q, rd_ptr_o + field_off};
endmodule

// File: rtl/rxres_fetch_chk.sv
module rxres_fetch_chk #(
   parameter int unsigned PTR_W  = 16,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned OUT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              mem_req_o,
   input logic              mem_valid_i,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic              busy_o,
   input logic              done_o,
   input logic [OUT_W-1:0]  buf_addr_o,
   input logic [OUT_W-1:0]  word_cnt_o,
   input logic [PTR_W-1:0]  rd_ptr_o,
   input logic [PTR_W-1:0]  write_ptr_i,
   input logic              exhausted_o
);
   AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> busy_o); // R2

   AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o); // R2

   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R4

   AST_COMMIT_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(buf_addr_o) && $stable(word_cnt_o))); // R5

   AST_EXH_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exhausted_o) |-> (done_o && rd_ptr_o == $past(write_ptr_i))); // R8

   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
endmodule

bind rxres_fetch rxres_fetch_chk #(
   .PTR_W  (PTR_W),
   .ADDR_W (ADDR_W),
   .OUT_W  (OUT_W)
) u_chk (.*);

// File: tb/rxres_fetch_bench.sv
module rxres_fetch_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        wide_i = 1'b0;
   logic [15:0] upper_i = 16'h0000;
   logic [15:0] ring_start_i = 16'h0000;
   logic [15:0] ring_end_i = 16'hFFF0;
   logic [15:0] write_ptr_i = 16'hEEEE;
   logic        ptr_load_i = 1'b0;
   logic [15:0] ptr_load_val_i = 16'h0000;
   logic        exh_clr_i = 1'b0;
   logic        mem_valid_i = 1'b0;
   logic [31:0] mem_rdata_i = '0;
   logic        mem_req_o;
   logic [31:0] mem_addr_o;
   logic        busy_o, done_o, exhausted_o;
   logic [31:0] buf_addr_o, word_cnt_o;
   logic [15:0] rd_ptr_o;

   int checks = 0;
   int errors = 0;
   int lat = 0;
   int wait_cnt = 0;
   int nlog = 0;
   int addr_chg = 0;
   int ndone = 0;
   logic [31:0] hold_addr = '0;
   logic [31:0] alog [0:15];

   rxres_fetch u_rxres_fetch (.*);

   always #10 clk = ~clk;

   function automatic logic [15:0] fld(input logic [31:0] a);
      return a[15:0] ^ a[31:16] ^ 16'h3C5A;
   endfunction

   // memory responder, drives at falling edges
   always @(negedge clk) begin
      if (done_o) ndone++;
      if (mem_valid_i) begin
         mem_valid_i = 1'b0;
         wait_cnt = 0;
      end else if (mem_req_o) begin
         if (wait_cnt == 0) hold_addr = mem_addr_o;
         else if (mem_addr_o != hold_addr) addr_chg++;
         if (wait_cnt >= lat) begin
            mem_valid_i = 1'b1;
            mem_rdata_i = {16'hDEAD ^ mem_addr_o[15:0], fld(mem_addr_o)};
            if (nlog < 16) alog[nlog] = mem_addr_o;
            nlog++;
            wait_cnt = 0;
         end else begin
            wait_cnt++;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_ptr(input logic [15:0] v);
      @(negedge clk); ptr_load_i = 1'b1; ptr_load_val_i = v;
      @(negedge clk); ptr_load_i = 1'b0;
   endtask

   // one fetch; optional mid-fetch start / pointer load
   task automatic fetch(input logic wide, input logic disturb, output int dones);
      int n;
      @(negedge clk);
      nlog = 0; ndone = 0; addr_chg = 0;
      wide_i = wide; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk("R2 busy after start", 32'(busy_o), 32'd1);
      n = 0;
      while (!done_o && n < 100) begin
         if (disturb && n == 2) begin
            start_i = 1'b1; ptr_load_i = 1'b1; ptr_load_val_i = 16'h7777;
         end else begin
            start_i = 1'b0; ptr_load_i = 1'b0;
         end
         @(negedge clk); n++;
      end
      start_i = 1'b0; ptr_load_i = 1'b0;
      chk("R9 done seen", 32'(done_o), 32'd1);
      chk("R9 busy low with done", 32'(busy_o), 32'd0);
      @(negedge clk);
      chk("R9 done one cycle", 32'(done_o), 32'd0);
      dones = ndone;
   endtask

   task automatic expect_fields(input string req, input logic [15:0] up,
                                input logic [15:0] rp, input int slot);
      logic [31:0] a [0:3];
      for (int k = 0; k < 4; k++) begin
         a[k] = {up, rp + 16'(k * slot)};
         chk(req, (k < nlog) ? alog[k] : 32'hFFFF_FFFF, a[k]);
      end
      chk("R5 buf addr", buf_addr_o, {fld(a[1]), fld(a[0])});
      chk("R5 word count", word_cnt_o, {fld(a[3]), fld(a[2])});
      chk("R11 high data bits ignored", 32'(buf_addr_o[15:0]), 32'(fld(a[0])));
   endtask

   task automatic t_reset();
      chk("R1 busy", 32'(busy_o), 0);
      chk("R1 done", 32'(done_o), 0);
      chk("R1 req", 32'(mem_req_o), 0);
      chk("R1 exhausted", 32'(exhausted_o), 0);
      chk("R1 buf", buf_addr_o, 0);
      chk("R1 cnt", word_cnt_o, 0);
      chk("R1 ptr", 32'(rd_ptr_o), 0);
   endtask

   task automatic t_narrow();
      int d;
      lat = 0; upper_i = 16'h1234;
      load_ptr(16'h0040);
      fetch(1'b0, 1'b0, d);
      chk("R2 four reads", nlog, 4);
      expect_fields("R2 narrow address", 16'h1234, 16'h0040, 2);
      chk("R6 narrow stride", 32'(rd_ptr_o), 32'h0048);
      chk("R8 no exhaust", 32'(exhausted_o), 0);
   endtask

   task automatic t_wide();
      int d;
      lat = 1; upper_i = 16'h00A0;
      load_ptr(16'h0200);
      fetch(1'b1, 1'b0, d);
      expect_fields("R3 wide address", 16'h00A0, 16'h0200, 4);
      chk("R6 wide stride", 32'(rd_ptr_o), 32'h0210);
   endtask

   task automatic t_hold();
      int d;
      logic [31:0] prev_buf;
      lat = 3; upper_i = 16'h0F0F;
      load_ptr(16'h0300);
      prev_buf = buf_addr_o;
      @(negedge clk); nlog = 0; ndone = 0; addr_chg = 0;
      wide_i = 1'b0; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (6) @(negedge clk);
      chk("R5 unchanged mid fetch", buf_addr_o, prev_buf);
      while (!done_o) @(negedge clk);
      @(negedge clk);
      chk("R4 address held", addr_chg, 0);
      expect_fields("R4 slow reads", 16'h0F0F, 16'h0300, 2);
      d = 0;
   endtask

   task automatic t_wrap();
      int d;
      lat = 0; upper_i = 16'h0001;
      ring_start_i = 16'h0100; ring_end_i = 16'h0200;
      load_ptr(16'h01F0);
      fetch(1'b1, 1'b0, d);
      chk("R7 wrap to ring start", 32'(rd_ptr_o), 32'h0100);
      load_ptr(16'h01F0);
      fetch(1'b0, 1'b0, d);
      chk("R7 no wrap short of end", 32'(rd_ptr_o), 32'h01F8);
   endtask

   task automatic t_exhaust();
      int d;
      lat = 0; write_ptr_i = 16'h0108;
      load_ptr(16'h0100);
      fetch(1'b0, 1'b0, d);
      chk("R8 exhausted set", 32'(exhausted_o), 1);
      write_ptr_i = 16'hEEEE;
      fetch(1'b0, 1'b0, d);
      chk("R8 exhausted sticky", 32'(exhausted_o), 1);
      @(negedge clk); exh_clr_i = 1'b1;
      @(negedge clk); exh_clr_i = 1'b0;
      chk("R8 exhausted cleared", 32'(exhausted_o), 0);
   endtask

   task automatic t_busy_ignore();
      int d;
      lat = 2; upper_i = 16'h5555;
      ring_end_i = 16'hFFF0;
      load_ptr(16'h0400);
      fetch(1'b0, 1'b1, d);
      repeat (12) @(negedge clk);
      chk("R10 no extra reads", nlog, 4);
      chk("R10 single done", ndone, 1);
      chk("R10 load ignored", 32'(rd_ptr_o), 32'h0408);
      chk("R10 still idle", 32'(busy_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_narrow();
      t_wide();
      t_hold();
      t_wrap();
      t_exhaust();
      t_busy_ignore();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule